// File: doc/BRIEF.md
# UART FIFO Control Unit with Receive Trigger

This block sits between a UART's bus-side register interface and its serial shifters. It keeps a byte-wide, write-only control register that picks a receive fill threshold, switches the FIFOs between a sixteen-byte mode and a single-byte holding mode, and turns the transmit and receive paths on and off. It owns two byte FIFOs, one per direction, each with a push port and a pop port. The host pushes transmit bytes and the transmit shifter pops them. The receive shifter pushes received bytes and the host pops them.

The path enables are level controls, not strobes. A path bit stays at whatever value was last written. While a path bit is 0, that direction's FIFO is held empty, and its run output tells the matching shifter to stay in reset, so the pointers and the shifter cannot drift apart. A receive-data request is raised whenever the receive FIFO holds at least the selected number of bytes. The control register is write-only; reads at the shared address belong to another block.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, both counts are 0, both pop data outputs are 0, both overrun outputs are 0, `rx_irq` is 0, and `tx_run` and `rx_run` are 0.
- R2: A write with `reg_wr` updates the control register at the next clock edge. Bit 2 of the written byte drives `tx_run` and bit 1 drives `rx_run`. Each bit keeps its value through idle cycles until a later write changes it.
- R3: While bit 2 is 0, the transmit FIFO stays empty (`tx_count` = 0) and transmit pushes are dropped without an overrun. Clearing bit 2 empties a transmit FIFO that holds data, with `tx_count` reading 0 two cycles after the write strobe.
- R4: While bit 1 is 0, the receive FIFO behaves the same way: `rx_count` = 0, pushes are dropped without an overrun, and contents are flushed when the bit is cleared.
- R5: With bit 0 (FIFO mode) set, each FIFO holds up to 16 bytes. Bytes come out in the order they were pushed, and the count output follows accepted pushes and pops.
- R6: A push to a full FIFO is dropped. The FIFO contents are unchanged, and that direction's overrun output is 1 for the single cycle after the push strobe.
- R7: A pop from an empty FIFO leaves the pop data output at its previous value and the count at 0.
- R8: With bit 0 set, bits [7:6] select the receive threshold: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. `rx_irq` is 1 exactly when `rx_count` is at least the threshold.
- R9: With bit 0 clear, each FIFO holds one byte, a second push overruns, and `rx_irq` is 1 whenever `rx_count` is at least 1, regardless of bits [7:6].
- R10: Bits [5:3] of a write have no effect. A byte with them set acts the same as the same byte with them clear.
- R11: Popped data appears on the pop data output in the cycle after the pop strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control byte written |
| tx_push | input | 1 | Host pushes a transmit byte |
| tx_push_data | input | 8 | Transmit byte from host |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_pop_data | output | 8 | Byte handed to transmit shifter |
| tx_count | output | 5 | Transmit FIFO occupancy |
| tx_overrun | output | 1 | Transmit push dropped last cycle |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_push_data | input | 8 | Received byte |
| rx_pop | input | 1 | Host takes a received byte |
| rx_pop_data | output | 8 | Received byte to host |
| rx_count | output | 5 | Receive FIFO occupancy |
| rx_overrun | output | 1 | Receive push dropped last cycle |
| rx_irq | output | 1 | Receive fill level reached threshold |
| tx_run | output | 1 | Transmit path enabled (shifter out of reset) |
| rx_run | output | 1 | Receive path enabled (shifter out of reset) |

## Verification
The receive FIFO is filled one byte at a time under each of the four threshold codes. This separates the codes from one another and catches an off-by-one comparison at every level. A burst of sixteen distinct transmit bytes followed by a seventeenth checks ordering, wrap and the full boundary. The same push sequence is repeated with FIFO mode off and with the threshold set to 14, which shows that the single-byte capacity and the fixed threshold of one take over. Writes that clear a path bit on a non-empty FIFO, and writes with only the reserved bits set, show that a flush happens only when an enable bit goes low.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_e;

    typedef struct packed {
        trig_e trig;
        logic  tx_en;
        logic  rx_en;
        logic  fifo_en;
    } ctrl_t;

    localparam int unsigned CTRL_TRIG_HI = 7;
    localparam int unsigned CTRL_TRIG_LO = 6;
    localparam int unsigned CTRL_TX_BIT  = 2;
    localparam int unsigned CTRL_RX_BIT  = 1;
    localparam int unsigned CTRL_FF_BIT  = 0;

    function automatic int unsigned trig_bytes(input trig_e t);
        case (t)
            TRIG_ONE:      return 1;
            TRIG_FOUR:     return 4;
            TRIG_EIGHT:    return 8;
            default:       return 14;
        endcase
    endfunction

    function automatic ctrl_t decode_ctrl(input logic [1:0] trig, input logic tx,
                                          input logic rx, input logic ff);
        ctrl_t c;
        c.trig    = trig_e'(trig);
        c.tx_en   = tx;
        c.rx_en   = rx;
        c.fifo_en = ff;
        return c;
    endfunction

endpackage

// File: rtl/ctrl_reg.sv
module ctrl_reg
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wdata,
    output ctrl_t      ctrl
);
    ctrl_t ctrl_q;
    logic  unused_rsvd;

    // Reserved field carries no function.
    assign unused_rsvd = ^wdata[5:3];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr) begin
            ctrl_q <= decode_ctrl(wdata[CTRL_TRIG_HI:CTRL_TRIG_LO], wdata[CTRL_TX_BIT],
                                  wdata[CTRL_RX_BIT], wdata[CTRL_FF_BIT]);
        end
    end

    assign ctrl = ctrl_q;

    assert_ctrl_persist_R2: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(ctrl_q));

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          one_deep,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    pop_data,
    output logic [CW-1:0] count,
    output logic          overrun
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cap;
    logic [7:0]    dout;
    logic          ovr;
    logic          pop_ok, push_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap     = one_deep ? CW'(1) : CW'(DEPTH);
    assign pop_ok  = pop && (cnt != '0);
    assign push_ok = push && ((cnt < cap) || pop_ok);

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            dout   <= '0;
            ovr    <= 1'b0;
        end else begin
            if (push_ok) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop_ok) begin
                dout   <= mem[rd_ptr];
                rd_ptr <= bump(rd_ptr);
            end
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
            ovr <= push && !push_ok;
        end
    end

    assign pop_data = dout;
    assign count    = cnt;
    assign overrun  = ovr;

    assert_count_cap_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // Holds for the transmit instance (R3) and the receive instance (R4).
    assert_flush_empty_R3: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));

    assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (rst)
        ovr |-> ($past(push) && ($past(cnt) == $past(cap))));

    assert_empty_pop_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (pop && (cnt == '0) && !clear) |=> $stable(dout));

    assert_one_deep_cap_R9: assert property (@(posedge clk) disable iff (rst)
        (one_deep && $past(one_deep) && ($past(cnt) <= CW'(1))) |-> (cnt <= CW'(1)));

endmodule

// File: rtl/rx_trigger.sv
module rx_trigger
    import uart_fifo_pkg::*;
#(
    parameter int CW = 5
) (
    input  trig_e         trig,
    input  logic          fifo_en,
    input  logic          rx_en,
    input  logic [CW-1:0] count,
    output logic          irq
);
    int unsigned need;

    always_comb begin
        need = fifo_en ? trig_bytes(trig) : 1;
        irq  = rx_en && (32'(count) >= need);
    end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    input  logic          tx_push,
    input  logic [7:0]    tx_push_data,
    input  logic          tx_pop,
    output logic [7:0]    tx_pop_data,
    output logic [CW-1:0] tx_count,
    output logic          tx_overrun,
    input  logic          rx_push,
    input  logic [7:0]    rx_push_data,
    input  logic          rx_pop,
    output logic [7:0]    rx_pop_data,
    output logic [CW-1:0] rx_count,
    output logic          rx_overrun,
    output logic          rx_irq,
    output logic          tx_run,
    output logic          rx_run
);
    localparam int NPATH = 2;   // index 0: transmit, 1: receive

    ctrl_t         ctrl;
    logic          clr     [NPATH];
    logic          f_push  [NPATH];
    logic          f_pop   [NPATH];
    logic [7:0]    f_din   [NPATH];
    logic [7:0]    f_dout  [NPATH];
    logic [CW-1:0] f_cnt   [NPATH];
    logic          f_ovr   [NPATH];

    ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .ctrl  (ctrl)
    );

    assign clr[0]    = !ctrl.tx_en;
    assign clr[1]    = !ctrl.rx_en;
    assign f_push[0] = tx_push;
    assign f_push[1] = rx_push;
    assign f_pop[0]  = tx_pop;
    assign f_pop[1]  = rx_pop;
    assign f_din[0]  = tx_push_data;
    assign f_din[1]  = rx_push_data;

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        byte_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .clear     (clr[p]),
            .one_deep  (!ctrl.fifo_en),
            .push      (f_push[p]),
            .push_data (f_din[p]),
            .pop       (f_pop[p]),
            .pop_data  (f_dout[p]),
            .count     (f_cnt[p]),
            .overrun   (f_ovr[p])
        );
    end

    rx_trigger #(.CW(CW)) u_trig (
        .trig    (ctrl.trig),
        .fifo_en (ctrl.fifo_en),
        .rx_en   (ctrl.rx_en),
        .count   (f_cnt[1]),
        .irq     (rx_irq)
    );

    assign tx_pop_data = f_dout[0];
    assign tx_count    = f_cnt[0];
    assign tx_overrun  = f_ovr[0];
    assign rx_pop_data = f_dout[1];
    assign rx_count    = f_cnt[1];
    assign rx_overrun  = f_ovr[1];
    assign tx_run      = ctrl.tx_en;
    assign rx_run      = ctrl.rx_en;

    assert_irq_needs_data_R8: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> (rx_count != '0));

    assert_run_gates_rx_R4: assert property (@(posedge clk) disable iff (rst)
        (!rx_run && $past(!rx_run)) |-> (rx_count == '0));

endmodule

// File: tb/uart_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_tb_top;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic clk = 1'b0, rst;
    logic reg_wr;
    logic [7:0] reg_wdata;
    logic tx_push, tx_pop, rx_push, rx_pop;
    logic [7:0] tx_push_data, rx_push_data, tx_pop_data, rx_pop_data;
    logic [CW-1:0] tx_count, rx_count;
    logic tx_overrun, rx_overrun, rx_irq, tx_run, rx_run;

    int total = 0, failed = 0;
    bit done = 1'b0;
    logic [7:0] txq[$], rxq[$];
    logic [7:0] last_tx = 8'h00, last_rx = 8'h00;
    logic [7:0] cur = 8'h00;
    int cap = 1;

    uart_fifo_ctrl #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .tx_count(tx_count), .tx_overrun(tx_overrun),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
        .rx_pop_data(rx_pop_data), .rx_count(rx_count), .rx_overrun(rx_overrun),
        .rx_irq(rx_irq), .tx_run(tx_run), .rx_run(rx_run)
    );

    always #2 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        step();
        reg_wr = 1'b0;
        cur = v;
        cap = v[0] ? DEPTH : 1;
        step();
        if (!v[2]) begin txq.delete(); last_tx = 8'h00; end
        if (!v[1]) begin rxq.delete(); last_rx = 8'h00; end
    endtask

    // Driver: pushes and records expected contents in the scoreboard queues.
    task automatic push_b(input int p, input logic [7:0] d, input string tag);
        logic acc;
        if (p == 0) begin tx_push = 1'b1; tx_push_data = d; end
        else        begin rx_push = 1'b1; rx_push_data = d; end
        step();
        tx_push = 1'b0; rx_push = 1'b0;
        if (p == 0) begin
            acc = cur[2] && (txq.size() < cap);
            if (acc) txq.push_back(d);
            chk(int'(tx_overrun), int'(cur[2] && !acc), "R6");
            chk(int'(tx_count), txq.size(), tag);
        end else begin
            acc = cur[1] && (rxq.size() < cap);
            if (acc) rxq.push_back(d);
            chk(int'(rx_overrun), int'(cur[1] && !acc), "R6");
            chk(int'(rx_count), rxq.size(), tag);
        end
    endtask

    // Monitor: pops and compares against the scoreboard.
    task automatic pop_b(input int p, input string tag);
        logic [7:0] e;
        if (p == 0) tx_pop = 1'b1; else rx_pop = 1'b1;
        step();
        tx_pop = 1'b0; rx_pop = 1'b0;
        if (p == 0) begin
            e = (txq.size() != 0) ? txq.pop_front() : last_tx;
            last_tx = e;
            chk(int'(tx_pop_data), int'(e), tag);
            chk(int'(tx_count), txq.size(), tag);
        end else begin
            e = (rxq.size() != 0) ? rxq.pop_front() : last_rx;
            last_rx = e;
            chk(int'(rx_pop_data), int'(e), tag);
            chk(int'(rx_count), rxq.size(), tag);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_wdata = 8'h00;
        tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
        tx_push_data = 8'h00; rx_push_data = 8'h00;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk(int'(tx_count), 0, "R1"); chk(int'(rx_count), 0, "R1");
        chk(int'(tx_pop_data), 0, "R1"); chk(int'(rx_pop_data), 0, "R1");
        chk(int'(tx_overrun), 0, "R1"); chk(int'(rx_overrun), 0, "R1");
        chk(int'(rx_irq), 0, "R1");
        chk(int'(tx_run), 0, "R1"); chk(int'(rx_run), 0, "R1");

        // R3 / R4: disabled paths drop pushes
        push_b(0, 8'hA1, "R3");
        push_b(1, 8'hB1, "R4");

        // R2: enable both paths, FIFO mode, threshold 1
        wr_ctrl(8'h07);
        chk(int'(tx_run), 1, "R2"); chk(int'(rx_run), 1, "R2");
        repeat (5) step();
        chk(int'(tx_run), 1, "R2"); chk(int'(rx_run), 1, "R2");

        // R5 / R6: fill transmit FIFO, overrun on 17th
        for (int i = 0; i < DEPTH; i++) push_b(0, 8'(8'h10 + i), "R5");
        push_b(0, 8'hEE, "R6");
        step();
        chk(int'(tx_overrun), 0, "R6");
        chk(int'(tx_count), DEPTH, "R6");
        for (int i = 0; i < DEPTH; i++) pop_b(0, "R11");
        // R7: empty pops hold the last byte
        pop_b(0, "R7");
        pop_b(0, "R7");

        // R8: each threshold code
        for (int s = 0; s < 4; s++) begin
            int lvl;
            lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            wr_ctrl(8'((s << 6) | 8'h07));
            chk(int'(rx_irq), 0, "R8");
            for (int i = 1; i <= 14; i++) begin
                push_b(1, 8'(s * 16 + i), "R5");
                chk(int'(rx_irq), int'(rxq.size() >= lvl), "R8");
            end
            for (int i = 0; i < 14; i++) pop_b(1, "R5");
            chk(int'(rx_irq), 0, "R8");
        end

        // R4: flush receive by clearing its enable
        for (int i = 0; i < 3; i++) push_b(1, 8'(8'h60 + i), "R5");
        wr_ctrl(8'h05);
        chk(int'(rx_run), 0, "R4"); chk(int'(rx_count), 0, "R4");
        chk(int'(rx_irq), 0, "R4");
        push_b(1, 8'h77, "R4");
        wr_ctrl(8'h07);
        push_b(1, 8'h78, "R4");
        pop_b(1, "R4");

        // R9: single-byte mode, threshold bits ignored
        wr_ctrl(8'hC6);
        chk(int'(rx_irq), 0, "R9");
        push_b(1, 8'h91, "R9");
        chk(int'(rx_irq), 1, "R9");
        push_b(1, 8'h92, "R9");
        chk(int'(rx_count), 1, "R9");
        pop_b(1, "R9");
        chk(int'(rx_irq), 0, "R9");
        push_b(0, 8'h93, "R9");
        push_b(0, 8'h94, "R9");
        pop_b(0, "R9");

        // R10: reserved bits ignored
        wr_ctrl(8'h3F);
        chk(int'(tx_run), 1, "R10"); chk(int'(rx_run), 1, "R10");
        push_b(1, 8'hA0, "R10");
        chk(int'(rx_irq), 1, "R10");
        for (int i = 1; i < DEPTH; i++) push_b(1, 8'(8'hA0 + i), "R10");
        chk(int'(rx_count), DEPTH, "R10");
        wr_ctrl(8'h38);
        chk(int'(tx_run), 0, "R10"); chk(int'(rx_run), 0, "R10");
        chk(int'(rx_count), 0, "R10");

        // R3: flush transmit with data inside
        wr_ctrl(8'h07);
        for (int i = 0; i < 3; i++) push_b(0, 8'(8'hC0 + i), "R5");
        wr_ctrl(8'h03);
        chk(int'(tx_count), 0, "R3"); chk(int'(tx_run), 0, "R3");
        chk(int'(tx_pop_data), 0, "R3");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule